// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides what a small processor core does once reset ends. While reset is low it samples three dedicated mode straps and a fourth strap that shares its pad with a general-purpose flag. The sampled value is held for the rest of the run, so the flag pad is free for normal use as soon as reset ends. While reset is held, and for the first clock after it, the block asks the core to empty its stacks, mask its interrupts and clear its status register.

After reset, and only once no external bus request is pending, the block takes one of three paths. In the byte boot it reads bytes from external byte memory through a request/acknowledge handshake. It packs each three bytes into a 24-bit program word and writes the words to program memory addresses 0 to 31, then releases the core to run from internal address 0. In the host boot it watches host-port writes and releases the core to run from internal address 0 when program address 0 is written. In the no-boot path it releases the core at once to fetch from external address 0. A one-cycle done pulse marks the release, and a separate output tells the pad logic whether to drive the host acknowledge actively.

Top module: `rst_boot_sequencer`

## Requirements
- R1: While `rst_ni` is low, `stack_clr_o`, `irq_mask_o` and `stat_clr_o` are 1 and `core_run_o` is 0. The three clear outputs stay 1 until the first rising clock edge after reset is released, and are 0 afterwards.
- R2: `strap_i` and `flag_pad_i` are sampled on every rising edge while `rst_ni` is low. The value from the last such edge selects the mode. Changes on these pins after release have no effect on the path taken or on `hostack_drv_o`.
- R3: While `bus_req_i` is 1 after reset, no boot starts: `bm_req_o` and `core_run_o` stay 0. The chosen path starts on the first rising edge at which `bus_req_i` is 0.
- R4: Mode priority is as follows. A latched flag strap of 1 selects no-boot. Otherwise `strap_i[1]`=1 and `strap_i[0]`=1 select host boot. Every other combination selects byte boot. No-boot sets `core_run_o`=1, `fetch_ext_o`=1 and `start_addr_o`=0 on the first edge after release when no bus request is pending, and makes no byte-memory reads.
- R5: Byte boot reads byte addresses 0, 1, 2, … in strict order. Each group of three bytes forms one word with the first byte in bits 23:16, the second in bits 15:8 and the third in bits 7:0. The words are written with `pm_we_o` to program addresses 0 to 31 in order, exactly 32 writes in total.
- R6: A byte transfer happens on a rising edge with `bm_req_o`=1 and `bm_ack_i`=1. While `bm_req_o` is 1 and no acknowledge has arrived, the request and `bm_addr_o` stay unchanged for any number of wait cycles.
- R7: In byte boot `core_run_o` rises only after the 32nd program write, with `fetch_ext_o`=0 and `start_addr_o`=0.
- R8: In host boot `core_run_o` stays 0 until an edge with `host_wr_i`=1 and `host_addr_i`=0. It is 1 from the next cycle, with `fetch_ext_o`=0. Host writes to other addresses do not release the core, and no byte-memory reads occur.
- R9: `boot_done_o` is 1 for exactly one cycle, the first cycle in which `core_run_o` is 1. `core_run_o` then stays 1 until the next reset.
- R10: `hostack_drv_o` is 1 exactly when the latched `strap_i[1]` (host mode) is 1 and the latched `strap_i[2]` (external pull-down) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; straps are sampled while low |
| strap_i | input | 3 | Dedicated straps: bit0 host-load select, bit1 host mode, bit2 external acknowledge pull-down |
| flag_pad_i | input | 1 | Shared flag pad; read as the no-boot strap during reset |
| bus_req_i | input | 1 | External bus request; holds off the boot |
| bm_req_o | output | 1 | Byte-memory read request |
| bm_addr_o | output | AW | Byte-memory read address |
| bm_ack_i | input | 1 | Byte-memory acknowledge; data valid |
| bm_data_i | input | BYTE_W | Byte-memory read data |
| pm_we_o | output | 1 | Program-memory write strobe |
| pm_addr_o | output | AW | Program-memory write address |
| pm_wdata_o | output | BYTE_W*WORD_BYTES | Program-memory write data |
| host_wr_i | input | 1 | Host-port write snoop strobe |
| host_addr_i | input | AW | Program address of the snooped host write |
| core_run_o | output | 1 | Core release |
| fetch_ext_o | output | 1 | First fetch comes from external memory |
| start_addr_o | output | AW | First fetch address |
| boot_done_o | output | 1 | One-cycle pulse at release |
| stack_clr_o | output | 1 | Empty all stack pointers |
| irq_mask_o | output | 1 | Mask all interrupts |
| stat_clr_o | output | 1 | Clear mode/status register |
| hostack_drv_o | output | 1 | Drive host acknowledge actively |

## Verification
The bench first reverses every strap and the flag pad just after release. A design that sampled its straps after reset would then take the wrong path, for example a byte boot that turns into an instant release. It runs the byte boot with back-to-back acknowledges and with three wait cycles per byte. A design that advanced the address without an acknowledge, or that packed bytes in the wrong order, would write wrong words. One that counted 31 or 33 words, or released the core before the last write, would show the wrong write count at the moment of release. Host boot is first given a write to a non-zero address, which a loose address compare would take as the release. A held bus request must delay both the instant release and the first byte request.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   typedef enum logic [2:0] {
      ST_RESET_HOLD = 3'd0,
      ST_WAIT_BUS   = 3'd1,
      ST_BDMA_READ  = 3'd2,
      ST_PM_WRITE   = 3'd3,
      ST_WAIT_HOST  = 3'd4,
      ST_RELEASE    = 3'd5
   } rbs_state_e;

   typedef enum logic [1:0] {
      BOOT_BYTE = 2'd0,
      BOOT_HOST = 2'd1,
      BOOT_NONE = 2'd2
   } rbs_boot_e;

   typedef struct packed {
      logic no_boot;
      logic ack_ext;
      logic host_en;
      logic host_dma;
   } rbs_mode_t;

endpackage

// File: rtl/rbs_strap_latch.sv
module rbs_strap_latch
   import rbs_pkg::*;
#(
   parameter bit FLAG_ACTIVE_HIGH = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] strap_i,
   input  logic       flag_pad_i,
   output rbs_mode_t  mode_o,
   output rbs_boot_e  boot_o,
   output logic       ack_drv_o
);

   logic      nb_raw;
   rbs_mode_t mode_q;

   // polarity of the shared flag strap
   generate
      if (FLAG_ACTIVE_HIGH) begin : g_nb_high
         assign nb_raw = flag_pad_i;
      end else begin : g_nb_low
         assign nb_raw = ~flag_pad_i;
      end
   endgenerate

   // sample only while reset is held; hold forever after
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= '{no_boot: nb_raw, ack_ext: strap_i[2],
                     host_en: strap_i[1], host_dma: strap_i[0]};
      end
   end

   always_comb begin
      if (mode_q.no_boot)                         boot_o = BOOT_NONE;
      else if (mode_q.host_en && mode_q.host_dma) boot_o = BOOT_HOST;
      else                                        boot_o = BOOT_BYTE;
   end

   assign mode_o    = mode_q;
   assign ack_drv_o = mode_q.host_en & ~mode_q.ack_ext;

endmodule

// File: rtl/rbs_word_pack.sv
module rbs_word_pack #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 3,
   localparam int WORD_W    = BYTE_W * WORD_BYTES
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] word_q;

   if (BYTE_W < 1 || WORD_BYTES < 1) begin : g_bad_cfg
      $error("rbs_word_pack: BYTE_W and WORD_BYTES must be at least 1");
   end

   // first byte ends up most significant
   generate
      if (WORD_BYTES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      word_q <= '0;
            else if (shift_i) word_q <= byte_i;
         end
      end else begin : g_shift
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      word_q <= '0;
            else if (shift_i) word_q <= {word_q[WORD_W-BYTE_W-1:0], byte_i};
         end
      end
   endgenerate

   assign word_o = word_q;

endmodule

// File: rtl/rbs_fsm.sv
module rbs_fsm
   import rbs_pkg::*;
#(
   parameter int          AW         = 14,
   parameter int          WORD_BYTES = 3,
   parameter int          BOOT_WORDS = 32,
   parameter logic [AW-1:0] BM_BASE  = '0,
   localparam int BC_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
   localparam int WC_W = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  rbs_boot_e     boot_i,
   input  logic          bus_req_i,
   input  logic          bm_ack_i,
   input  logic          host_wr_i,
   input  logic [AW-1:0] host_addr_i,
   output rbs_state_e    st_o,
   output logic          bm_req_o,
   output logic [AW-1:0] bm_addr_o,
   output logic          shift_o,
   output logic          pm_we_o,
   output logic [AW-1:0] pm_addr_o,
   output logic          done_o
);

   localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(WORD_BYTES - 1);
   localparam logic [WC_W-1:0] LAST_WORD = WC_W'(BOOT_WORDS - 1);

   if (BOOT_WORDS < 1 || WC_W > AW) begin : g_bad_cfg
      $error("rbs_fsm: BOOT_WORDS must be at least 1 and fit in AW bits");
   end

   rbs_state_e      st_q, st_d;
   logic [BC_W-1:0] byte_cnt_q;
   logic [WC_W-1:0] word_cnt_q;
   logic [AW-1:0]   bm_addr_q;
   logic            done_q;
   logic            take_byte;
   rbs_state_e      start_st;

   assign take_byte = (st_q == ST_BDMA_READ) && bm_ack_i;

   always_comb begin
      unique case (boot_i)
         BOOT_NONE: start_st = ST_RELEASE;
         BOOT_HOST: start_st = ST_WAIT_HOST;
         default:   start_st = ST_BDMA_READ;
      endcase
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RESET_HOLD, ST_WAIT_BUS:
            st_d = bus_req_i ? ST_WAIT_BUS : start_st;
         ST_BDMA_READ:
            if (take_byte && byte_cnt_q == LAST_BYTE) st_d = ST_PM_WRITE;
         ST_PM_WRITE:
            st_d = (word_cnt_q == LAST_WORD) ? ST_RELEASE : ST_BDMA_READ;
         ST_WAIT_HOST:
            if (host_wr_i && host_addr_i == '0) st_d = ST_RELEASE;
         ST_RELEASE:
            st_d = ST_RELEASE;
         default:
            st_d = ST_RESET_HOLD;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q       <= ST_RESET_HOLD;
         byte_cnt_q <= '0;
         word_cnt_q <= '0;
         bm_addr_q  <= BM_BASE;
         done_q     <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_d == ST_RELEASE) && (st_q != ST_RELEASE);
         if (take_byte) begin
            bm_addr_q  <= bm_addr_q + 1'b1;
            byte_cnt_q <= (byte_cnt_q == LAST_BYTE) ? '0 : byte_cnt_q + 1'b1;
         end
         if (st_q == ST_PM_WRITE) word_cnt_q <= word_cnt_q + 1'b1;
      end
   end

   assign st_o      = st_q;
   assign bm_req_o  = (st_q == ST_BDMA_READ);
   assign bm_addr_o = bm_addr_q;
   assign shift_o   = take_byte;
   assign pm_we_o   = (st_q == ST_PM_WRITE);
   assign pm_addr_o = AW'(word_cnt_q);
   assign done_o    = done_q;

endmodule

// File: rtl/rst_boot_sequencer.sv
module rst_boot_sequencer
   import rbs_pkg::*;
#(
   parameter int            AW               = 14,
   parameter int            BYTE_W           = 8,
   parameter int            WORD_BYTES       = 3,
   parameter int            BOOT_WORDS       = 32,
   parameter logic [AW-1:0] BM_BASE          = '0,
   parameter logic [AW-1:0] INT_START        = '0,
   parameter logic [AW-1:0] EXT_START        = '0,
   parameter bit            FLAG_ACTIVE_HIGH = 1'b1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [2:0]                   strap_i,
   input  logic                         flag_pad_i,
   input  logic                         bus_req_i,
   output logic                         bm_req_o,
   output logic [AW-1:0]                bm_addr_o,
   input  logic                         bm_ack_i,
   input  logic [BYTE_W-1:0]            bm_data_i,
   output logic                         pm_we_o,
   output logic [AW-1:0]                pm_addr_o,
   output logic [BYTE_W*WORD_BYTES-1:0] pm_wdata_o,
   input  logic                         host_wr_i,
   input  logic [AW-1:0]                host_addr_i,
   output logic                         core_run_o,
   output logic                         fetch_ext_o,
   output logic [AW-1:0]                start_addr_o,
   output logic                         boot_done_o,
   output logic                         stack_clr_o,
   output logic                         irq_mask_o,
   output logic                         stat_clr_o,
   output logic                         hostack_drv_o
);

   rbs_mode_t  mode;
   rbs_boot_e  boot;
   rbs_state_e st;
   logic       shift;
   logic       in_hold;

   rbs_strap_latch #(.FLAG_ACTIVE_HIGH(FLAG_ACTIVE_HIGH)) u_strap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strap_i   (strap_i),
      .flag_pad_i(flag_pad_i),
      .mode_o    (mode),
      .boot_o    (boot),
      .ack_drv_o (hostack_drv_o)
   );

   rbs_fsm #(
      .AW        (AW),
      .WORD_BYTES(WORD_BYTES),
      .BOOT_WORDS(BOOT_WORDS),
      .BM_BASE   (BM_BASE)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .boot_i     (boot),
      .bus_req_i  (bus_req_i),
      .bm_ack_i   (bm_ack_i),
      .host_wr_i  (host_wr_i),
      .host_addr_i(host_addr_i),
      .st_o       (st),
      .bm_req_o   (bm_req_o),
      .bm_addr_o  (bm_addr_o),
      .shift_o    (shift),
      .pm_we_o    (pm_we_o),
      .pm_addr_o  (pm_addr_o),
      .done_o     (boot_done_o)
   );

   rbs_word_pack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_pack (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift),
      .byte_i (bm_data_i),
      .word_o (pm_wdata_o)
   );

   assign in_hold      = (st == ST_RESET_HOLD);
   assign stack_clr_o  = in_hold;
   assign irq_mask_o   = in_hold;
   assign stat_clr_o   = in_hold;
   assign core_run_o   = (st == ST_RELEASE);
   assign fetch_ext_o  = core_run_o && (boot == BOOT_NONE);
   assign start_addr_o = fetch_ext_o ? EXT_START : INT_START;

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
   import rbs_pkg::*;
#(
   parameter int AW         = 14,
   parameter int BOOT_WORDS = 32
) (
   input logic          clk_i,
   input logic          rst_ni,
   input rbs_state_e    st,
   input rbs_mode_t     mode,
   input logic          bus_req_i,
   input logic          bm_req_o,
   input logic          bm_ack_i,
   input logic [AW-1:0] bm_addr_o,
   input logic          pm_we_o,
   input logic [AW-1:0] pm_addr_o,
   input logic          host_wr_i,
   input logic [AW-1:0] host_addr_i,
   input logic          core_run_o,
   input logic          boot_done_o,
   input logic          stack_clr_o,
   input logic          irq_mask_o,
   input logic          stat_clr_o
);

   // R1
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         clr_in_reset_chk: assert (stack_clr_o && irq_mask_o && stat_clr_o && !core_run_o)
            else $error("clear outputs not active during reset");
      end
   end

   // R2
   mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stack_clr_o |-> $stable(mode));

   // R3
   bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WAIT_BUS && bus_req_i) |=> (st == ST_WAIT_BUS));

   // R6
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bm_req_o && !bm_ack_i) |=> (bm_req_o && $stable(bm_addr_o)));

   // R5
   pm_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pm_we_o |-> (pm_addr_o < AW'(BOOT_WORDS)));

   // R8
   host_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WAIT_HOST && !(host_wr_i && host_addr_i == '0)) |=> !core_run_o);

   // R9
   done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_done_o |=> !boot_done_o);

   // R9
   run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_run_o |=> core_run_o);

endmodule

bind rst_boot_sequencer rbs_checker #(.AW(AW), .BOOT_WORDS(BOOT_WORDS)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .st         (st),
   .mode       (mode),
   .bus_req_i  (bus_req_i),
   .bm_req_o   (bm_req_o),
   .bm_ack_i   (bm_ack_i),
   .bm_addr_o  (bm_addr_o),
   .pm_we_o    (pm_we_o),
   .pm_addr_o  (pm_addr_o),
   .host_wr_i  (host_wr_i),
   .host_addr_i(host_addr_i),
   .core_run_o (core_run_o),
   .boot_done_o(boot_done_o),
   .stack_clr_o(stack_clr_o),
   .irq_mask_o (irq_mask_o),
   .stat_clr_o (stat_clr_o)
);

// File: tb/rst_boot_sequencer_tb.sv
`timescale 1ns/1ps
module rst_boot_sequencer_tb_top;

   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    strap = 3'b000;
   logic          flag = 1'b0;
   logic          bus_req = 1'b0;
   logic          bm_req_o;
   logic [AW-1:0] bm_addr_o;
   logic          bm_ack_i = 1'b0;
   logic [7:0]    bm_data_i = '0;
   logic          pm_we_o;
   logic [AW-1:0] pm_addr_o;
   logic [23:0]   pm_wdata_o;
   logic          host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic          core_run_o, fetch_ext_o, boot_done_o;
   logic [AW-1:0] start_addr_o;
   logic          stack_clr_o, irq_mask_o, stat_clr_o, hostack_drv_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rst_boot_sequencer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .flag_pad_i(flag),
      .bus_req_i(bus_req), .bm_req_o(bm_req_o), .bm_addr_o(bm_addr_o),
      .bm_ack_i(bm_ack_i), .bm_data_i(bm_data_i), .pm_we_o(pm_we_o),
      .pm_addr_o(pm_addr_o), .pm_wdata_o(pm_wdata_o), .host_wr_i(host_wr),
      .host_addr_i(host_addr), .core_run_o(core_run_o), .fetch_ext_o(fetch_ext_o),
      .start_addr_o(start_addr_o), .boot_done_o(boot_done_o),
      .stack_clr_o(stack_clr_o), .irq_mask_o(irq_mask_o), .stat_clr_o(stat_clr_o),
      .hostack_drv_o(hostack_drv_o)
   );

   function automatic logic [7:0] bval(logic [AW-1:0] a);
      logic [AW-1:0] t;
      t = a * 7 + (a >> 3) + 14'h5A;
      return t[7:0];
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // byte memory model
   int            wait_cfg = 0;
   int            wcnt = 0;
   logic [AW-1:0] exp_addr = '0;
   int            addr_err = 0;
   always @(negedge clk) begin
      if (bm_req_o) begin
         if (wcnt >= wait_cfg) begin
            bm_ack_i  <= 1'b1;
            bm_data_i <= bval(bm_addr_o);
            if (bm_addr_o != exp_addr) addr_err = addr_err + 1;
            exp_addr = bm_addr_o + 1'b1;
            wcnt = 0;
         end else begin
            bm_ack_i <= 1'b0;
            wcnt = wcnt + 1;
         end
      end else begin
         bm_ack_i <= 1'b0;
         wcnt = 0;
      end
   end

   // output monitor
   logic [AW-1:0] wa [64];
   logic [23:0]   wd [64];
   int nwr = 0, ndone = 0, wr_at_run = -1;
   bit run_seen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pm_we_o) begin
            if (nwr < 64) begin
               wa[nwr] = pm_addr_o;
               wd[nwr] = pm_wdata_o;
            end
            nwr = nwr + 1;
         end
         if (boot_done_o) ndone = ndone + 1;
         if (core_run_o && !run_seen) begin
            run_seen  = 1;
            wr_at_run = nwr;
         end
      end
   end

   // hold reset with given straps, release, then invert the pins (R2)
   task automatic apply_reset(logic [2:0] s, logic f, logic br);
      @(negedge clk);
      rst_n = 1'b0; strap = s; flag = f; bus_req = br;
      host_wr = 1'b0; host_addr = '0;
      nwr = 0; ndone = 0; run_seen = 0; wr_at_run = -1;
      wcnt = 0; exp_addr = '0; addr_err = 0;
      repeat (4) @(negedge clk);
      chk("R1", "clears in reset", {stack_clr_o, irq_mask_o, stat_clr_o, core_run_o}, 4'b1110);
      rst_n = 1'b1;
      strap = ~s;
      flag  = ~f;
   endtask

   task automatic test_noboot();
      apply_reset(3'b011, 1'b1, 1'b0);
      @(negedge clk); #1;
      chk("R1", "clears after release", {stack_clr_o, irq_mask_o, stat_clr_o}, 3'b000);
      chk("R4", "no-boot run/ext", {core_run_o, fetch_ext_o}, 2'b11);
      chk("R4", "no-boot start addr", start_addr_o, 0);
      chk("R9", "done pulse high", boot_done_o, 1);
      chk("R10", "ack drive host/internal", hostack_drv_o, 1);
      @(negedge clk); #1;
      chk("R9", "done pulse one cycle", boot_done_o, 0);
      chk("R9", "run sticky", core_run_o, 1);
      chk("R4", "no byte reads", addr_err + (exp_addr != 0 ? 1 : 0), 0);
   endtask

   task automatic test_bus_wait();
      apply_reset(3'b000, 1'b1, 1'b1);
      repeat (6) @(negedge clk);
      #1;
      chk("R3", "held by bus request", core_run_o, 0);
      chk("R1", "clears dropped while waiting", stack_clr_o, 0);
      bus_req = 1'b0;
      @(negedge clk); #1;
      chk("R3", "release after bus drop", {core_run_o, boot_done_o}, 2'b11);
   endtask

   task automatic test_byte_boot(logic [2:0] s, int wt, logic br);
      int bad;
      wait_cfg = wt;
      apply_reset(s, 1'b0, br);
      if (br) begin
         repeat (5) @(negedge clk);
         #1;
         chk("R3", "no byte request during bus request", bm_req_o, 0);
         bus_req = 1'b0;
         @(negedge clk); #1;
         chk("R3", "byte request after bus drop", bm_req_o, 1);
      end
      for (int i = 0; i < 20000 && !core_run_o; i++) @(negedge clk);
      @(negedge clk); #1;
      chk("R5", "write count", nwr, 32);
      chk("R7", "writes before release", wr_at_run, 32);
      bad = 0;
      for (int k = 0; k < 32 && k < nwr; k++) begin
         if (wa[k] != AW'(k)) bad++;
         if (wd[k] != {bval(AW'(3*k)), bval(AW'(3*k+1)), bval(AW'(3*k+2))}) bad++;
      end
      chk("R5", "word address/data mismatches", bad, 0);
      chk("R6", "byte address order errors", addr_err, 0);
      chk("R7", "internal start", {core_run_o, fetch_ext_o}, 2'b10);
      chk("R7", "start address", start_addr_o, 0);
      chk("R9", "done pulse count", ndone, 1);
      wait_cfg = 0;
   endtask

   task automatic test_host();
      apply_reset(3'b011, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      #1;
      chk("R2", "flag change after reset ignored", core_run_o, 0);
      chk("R8", "no byte reads in host boot", bm_req_o, 0);
      host_wr = 1'b1; host_addr = 14'd5;
      @(negedge clk);
      host_wr = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R8", "non-zero write ignored", core_run_o, 0);
      host_wr = 1'b1; host_addr = '0;
      @(negedge clk);
      host_wr = 1'b0;
      #1;
      chk("R8", "released by address 0", {core_run_o, fetch_ext_o, boot_done_o}, 3'b101);
      chk("R8", "no program writes", nwr, 0);
   endtask

   task automatic test_ack();
      apply_reset(3'b111, 1'b1, 1'b0);
      @(negedge clk); #1;
      chk("R10", "external pull-down", hostack_drv_o, 0);
      apply_reset(3'b001, 1'b1, 1'b0);
      @(negedge clk); #1;
      chk("R10", "host mode off", hostack_drv_o, 0);
      apply_reset(3'b010, 1'b1, 1'b0);
      @(negedge clk); #1;
      chk("R10", "host mode, internal drive", hostack_drv_o, 1);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      test_noboot();
      test_bus_wait();
      test_byte_boot(3'b000, 0, 1'b0);
      test_byte_boot(3'b010, 3, 1'b1);
      test_host();
      test_ack();
      finish_run();
   end

endmodule